// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit condition and state word of a small processor core. Each cycle it can take the outcome of one ALU operation and derive the arithmetic flags from it: carry, half carry, zero and signed overflow. The ALU supplies the result, its carry out of the top bit, its carry out of the low nibble and the sign bits of both operands. The operation class tells the block which flags that operation may touch. The class values are add, subtract, logic and rotate through carry.

Software can also load the register directly. A direct write changes only the four arithmetic flags. The sleep flag and the watchdog time-out flag ignore such writes. These two flags move only on four event strobes: power-up, watchdog clear, halt and watchdog time-out. The register is never saved or restored on its own. Code that calls a subroutine or takes an interrupt must save it explicitly.

Top module: `cpu_status_reg`

## Requirements
- R1: The packed word is {0, 0, TO, PD, OV, Z, AC, C}, with C at bit 0 and TO at bit 5. Bits 7 and 6 always read 0. After reset (rst_n low) the whole word is 0.
- R2: For an add (op_class 0, op_valid 1), C takes carry_out and AC takes nib_carry, the carry out of bit 3.
- R3: For a subtract (op_class 1), the ALU computes a + ~b + 1. C takes carry_out, so C = 1 means no borrow (a >= b unsigned). AC takes nib_carry, so AC = 1 means no borrow out of the low nibble.
- R4: For an add, a subtract or a logic operation (op_class 2), Z is 1 exactly when the result is all zeros.
- R5: For an add or a subtract, OV is the XOR of carry_out and the carry into the top bit. The carry into the top bit is found from opa_msb, from opb_msb (inverted for a subtract) and from the top bit of the result.
- R6: A logic operation changes only Z. A rotate (op_class 3) changes only C, which takes carry_out.
- R7: A write (wr_en 1) loads wr_data[3:0] into {OV, Z, AC, C}. It leaves PD and TO unchanged, and wr_data[7:4] have no effect.
- R8: When a write and an operation fall in the same cycle, the write value wins for C, AC, Z and OV.
- R9: PD is cleared by pwr_up or wdt_clr and set by halt. Clearing wins over halt.
- R10: TO is set by wdt_tmo and cleared by wdt_clr or halt. A time-out wins over a clear or a halt in the same cycle. pwr_up clears TO and wins over everything.
- R11: With op_valid 0, wr_en 0 and no event strobe, the word holds its value whatever the ALU inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An ALU operation completes this cycle |
| op_class | input | 2 | 0 add, 1 subtract, 2 logic, 3 rotate through carry |
| opa_msb | input | 1 | Top bit of operand a |
| opb_msb | input | 1 | Top bit of operand b, not inverted |
| result | input | W | ALU result |
| carry_out | input | 1 | Carry out of the top bit, or the bit rotated out |
| nib_carry | input | 1 | Carry out of bit 3 |
| wr_en | input | 1 | Direct register write |
| wr_data | input | 8 | Write data, bits 3:0 used |
| pwr_up | input | 1 | Power-up event |
| wdt_clr | input | 1 | Watchdog clear event |
| halt | input | 1 | Halt event |
| wdt_tmo | input | 1 | Watchdog time-out event |
| status | output | 8 | Packed register value |
| flag_c | output | 1 | Carry |
| flag_ac | output | 1 | Half carry |
| flag_z | output | 1 | Zero |
| flag_ov | output | 1 | Overflow |
| flag_pd | output | 1 | Sleep flag |
| flag_to | output | 1 | Watchdog time-out flag |

## Verification
The hardest cases to reach are the collisions in a single cycle. These are a time-out arriving together with a halt or a watchdog clear, power-up arriving together with a time-out, and a direct write landing on the same edge as a flag-producing operation. The bench raises these strobes together on one edge and checks the packed word on the next falling edge. A walked table of add, subtract, logic and rotate vectors runs on top of a running model. That model proves that logic operations and rotates keep the flags they must not touch.

// File: rtl/cpu_status_reg.sv
module cpu_status_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [1:0]   op_class,
  input  logic         opa_msb,
  input  logic         opb_msb,
  input  logic [W-1:0] result,
  input  logic         carry_out,
  input  logic         nib_carry,
  input  logic         wr_en,
  input  logic [7:0]   wr_data,
  input  logic         pwr_up,
  input  logic         wdt_clr,
  input  logic         halt,
  input  logic         wdt_tmo,
  output logic [7:0]   status,
  output logic         flag_c,
  output logic         flag_ac,
  output logic         flag_z,
  output logic         flag_ov,
  output logic         flag_pd,
  output logic         flag_to
);
  localparam logic [1:0] OP_ADD = 2'd0;
  localparam logic [1:0] OP_SUB = 2'd1;
  localparam logic [1:0] OP_LOG = 2'd2;
  localparam logic [1:0] OP_ROT = 2'd3;
  localparam int MSB = W - 1;

  logic c_q, ac_q, z_q, ov_q, pd_q, to_q;
  logic c_d, ac_d, z_d, ov_d, pd_d, to_d;
  logic arith, b_eff, cin_msb, res_zero;
  logic unused_wr_hi;

  assign unused_wr_hi = ^wr_data[7:4];
  assign arith    = op_valid && (op_class == OP_ADD || op_class == OP_SUB);
  assign b_eff    = (op_class == OP_SUB) ? ~opb_msb : opb_msb;
  assign cin_msb  = result[MSB] ^ opa_msb ^ b_eff;
  assign res_zero = (result == '0);

  always_comb begin
    c_d  = c_q;
    ac_d = ac_q;
    z_d  = z_q;
    ov_d = ov_q;
    if (arith) begin
      c_d  = carry_out;
      ac_d = nib_carry;
      z_d  = res_zero;
      ov_d = carry_out ^ cin_msb;
    end else if (op_valid && op_class == OP_LOG) begin
      z_d = res_zero;
    end else if (op_valid && op_class == OP_ROT) begin
      c_d = carry_out;
    end
    if (wr_en) {ov_d, z_d, ac_d, c_d} = wr_data[3:0];
  end

  always_comb begin
    pd_d = pd_q;
    if (pwr_up || wdt_clr) pd_d = 1'b0;
    else if (halt)         pd_d = 1'b1;
  end

  always_comb begin
    to_d = to_q;
    if (pwr_up)               to_d = 1'b0;
    else if (wdt_tmo)         to_d = 1'b1;
    else if (wdt_clr || halt) to_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {to_q, pd_q, ov_q, z_q, ac_q, c_q} <= '0;
    end else begin
      {to_q, pd_q, ov_q, z_q, ac_q, c_q} <= {to_d, pd_d, ov_d, z_d, ac_d, c_d};
    end
  end

  assign status  = {2'b00, to_q, pd_q, ov_q, z_q, ac_q, c_q};
  assign flag_c  = c_q;
  assign flag_ac = ac_q;
  assign flag_z  = z_q;
  assign flag_ov = ov_q;
  assign flag_pd = pd_q;
  assign flag_to = to_q;

  a_r7_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> status[3:0] == $past(wr_data[3:0]));
  a_r7_pd_to_ignore_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_up && !wdt_clr && !halt && !wdt_tmo) |=> $stable({flag_pd, flag_to}));
  a_r6_logic_keeps_carries: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == OP_LOG && !wr_en) |=> $stable({flag_c, flag_ac, flag_ov}));
  a_r9_halt_sets_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !pwr_up && !wdt_clr) |=> flag_pd);
  a_r9_clear_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up || wdt_clr) |=> !flag_pd);
  a_r10_tmo_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_tmo && !pwr_up) |=> flag_to);
  a_r10_pwr_up_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> !flag_to);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:6] == 2'b00);
endmodule

// File: tb/cpu_status_reg_bench.sv
`timescale 1ns/1ps
module cpu_status_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 0, opa_msb = 0, opb_msb = 0, carry_out = 0, nib_carry = 0;
  logic [1:0] op_class = 0;
  logic [7:0] result = 0, wr_data = 0;
  logic wr_en = 0, pwr_up = 0, wdt_clr = 0, halt = 0, wdt_tmo = 0;
  logic [7:0] status;
  logic flag_c, flag_ac, flag_z, flag_ov, flag_pd, flag_to;
  int checks = 0, errors = 0;
  logic mc = 0, mac = 0, mz = 0, mov = 0, mpd = 0, mto = 0;

  always #2 clk = ~clk;

  cpu_status_reg #(.W(8)) u_cpu_status_reg (
    .clk, .rst_n, .op_valid, .op_class, .opa_msb, .opb_msb, .result,
    .carry_out, .nib_carry, .wr_en, .wr_data, .pwr_up, .wdt_clr, .halt,
    .wdt_tmo, .status, .flag_c, .flag_ac, .flag_z, .flag_ov, .flag_pd, .flag_to);

  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'h00}, {2'd0, 8'h0F, 8'h01}, {2'd0, 8'hFF, 8'h01},
    {2'd0, 8'h7F, 8'h01}, {2'd0, 8'h80, 8'h80}, {2'd1, 8'h05, 8'h03},
    {2'd2, 8'hF0, 8'h0F}, {2'd1, 8'h03, 8'h05}, {2'd3, 8'h80, 8'h00},
    {2'd1, 8'h80, 8'h01}, {2'd2, 8'hFF, 8'h01}, {2'd1, 8'h10, 8'h10},
    {2'd3, 8'h01, 8'h00}};

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model();
    return {2'b00, mto, mpd, mov, mz, mac, mc};
  endfunction

  task automatic tick();
    @(negedge clk);
    op_valid = 0; wr_en = 0; pwr_up = 0; wdt_clr = 0; halt = 0; wdt_tmo = 0;
  endtask

  task automatic drive_op(logic [1:0] cls, logic [7:0] a, logic [7:0] b);
    logic [8:0] s;
    logic [4:0] n;
    op_class = cls; opa_msb = a[7]; opb_msb = b[7]; op_valid = 1;
    case (cls)
      2'd0: begin s = {1'b0, a} + {1'b0, b}; n = {1'b0, a[3:0]} + {1'b0, b[3:0]};
                  result = s[7:0]; carry_out = s[8]; nib_carry = n[4]; end
      2'd1: begin s = {1'b0, a} + {1'b0, ~b} + 9'd1; n = {1'b0, a[3:0]} + {1'b0, ~b[3:0]} + 5'd1;
                  result = s[7:0]; carry_out = s[8]; nib_carry = n[4]; end
      2'd2: begin result = a & b; carry_out = 1; nib_carry = 1; end
      default: begin result = {a[6:0], mc}; carry_out = a[7]; nib_carry = 1; end
    endcase
  endtask

  task automatic update_model(logic [1:0] cls, logic [7:0] a, logic [7:0] b);
    logic [7:0] r;
    case (cls)
      2'd0: begin r = a + b; mc = ({1'b0, a} + {1'b0, b}) > 9'h0FF;
                  mac = (a[3:0] + b[3:0]) > 5'd15; mz = (r == 0);
                  mov = (a[7] == b[7]) && (r[7] != a[7]); end
      2'd1: begin r = a - b; mc = a >= b; mac = a[3:0] >= b[3:0]; mz = (r == 0);
                  mov = (a[7] != b[7]) && (r[7] != a[7]); end
      2'd2: mz = ((a & b) == 0);
      default: mc = a[7];
    endcase
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", status, 8'h00);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive_op(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0]);
      update_model(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0]);
      tick();
      chk($sformatf("R2 R3 R4 R5 R6 vector %0d", i), status, model());
    end

    wr_en = 1; wr_data = 8'hFF; tick();
    chk("R7 write all ones, R1 reserved", status, 8'h0F);
    halt = 1; tick();
    chk("R9 halt sets PD", status, 8'h1F);
    wdt_tmo = 1; tick();
    chk("R10 timeout sets TO", status, 8'h3F);
    wr_en = 1; wr_data = 8'hC0; tick();
    chk("R7 write keeps PD TO", status, 8'h30);
    wr_en = 1; wr_data = 8'h05; drive_op(2'd0, 8'hFF, 8'h01); tick();
    chk("R8 write beats add", status, 8'h35);
    result = 8'h00; carry_out = 1; nib_carry = 1; opa_msb = 1; wr_data = 8'h0A;
    tick();
    chk("R11 idle ignores inputs", status, 8'h35);
    wdt_clr = 1; tick();
    chk("R9 R10 watchdog clear", status, 8'h05);
    halt = 1; wdt_tmo = 1; tick();
    chk("R10 timeout beats halt", status, 8'h35);
    wdt_clr = 1; wdt_tmo = 1; tick();
    chk("R10 timeout beats clear, R9 clear PD", status, 8'h25);
    halt = 1; wdt_clr = 1; tick();
    chk("R9 clear beats halt", status, 8'h05);
    halt = 1; tick();
    pwr_up = 1; wdt_tmo = 1; tick();
    chk("R10 power-up beats timeout", status, 8'h05);
    chk("R1 flag ports", {2'b00, flag_to, flag_pd, flag_ov, flag_z, flag_ac, flag_c}, 8'h05);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule